// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block performs the processor-side entry into an interrupt service routine once an arbiter has granted a request. It samples a one-cycle acknowledge together with the interrupt index, the current program counter, the flag byte, the code segment byte, the stack pointer, the vector base and two configuration bits. It then waits until the core reports that the running instruction has left its non-interruptable window. The core signals this with a pulse whose timing varies by instruction, from 1 clock up to 22 clocks (20 for multiply and word divide, about 16 for most others).

Entry begins with a one-cycle pulse that clears the global interrupt enable. The block then writes bytes to the system stack through a byte-wide write port. The stack pointer is pre-decremented for every byte. The block then reads a 16-bit handler address as two bytes through a vector read port. It raises a done strobe in the cycle where the new program counter and the new stack pointer are presented.

The entry length depends on two settings. A stack held in the register file is slower than a stack in memory, because no fetch can overlap its pushes. An optional code-segment push adds 2 clocks.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset, `busy_o`, `ien_clr_o`, `stk_we_o`, `vec_re_o` and `done_o` are all low.
- R2: Entry does not start until `nis_end_i` is seen high while waiting. In the cycle after that, `ien_clr_o` pulses for one cycle. No stack write or vector read happens before that pulse or during it.
- R3: Counting from the `ien_clr_o` cycle as 0, stack writes occur at cycles 2, 4, 6 and, with segment save, 8. Each write goes to the next lower byte address, starting at SP-1 with 16-bit wrap. The byte order is PC bits 7:0, then PC bits 15:8, then flags, then the code segment byte.
- R4: `done_o` rises at cycle L-1, where L is 18 for a memory stack without segment save. L is 20 with the register-file stack (`stk_rf_i`=1) or with segment save (`seg_save_i`=1). L is 22 with both.
- R5: The vector address is the vector base plus twice the index, with 16-bit wrap. The low byte is read at that address in cycle L-5 and the high byte at address+1 in cycle L-3. Each byte is returned by `vec_rdata_i` in the cycle after its read. On `done_o`, `pc_new_o` equals {high, low}.
- R6: `done_o` is a single-cycle pulse. With it, `sp_new_o` equals the sampled SP minus the number of bytes pushed (3 or 4). `busy_o` falls in the next cycle.
- R7: An acknowledge that arrives while `busy_o` is high is ignored. The ongoing entry keeps its original index and operands, and no second entry follows.
- R8: All operands and configuration bits are sampled in the acknowledge cycle. Later changes to them do not alter the stack writes, the vector addresses or the timing of the current entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ack_i | input | 1 | Interrupt granted, one cycle |
| idx_i | input | IDX_W | Index of the granted interrupt |
| nis_end_i | input | 1 | Current instruction left its non-interruptable window |
| stk_rf_i | input | 1 | Stack is in the register file |
| seg_save_i | input | 1 | Also push the code segment byte |
| pc_i | input | 16 | Program counter to save |
| flags_i | input | 8 | Flag byte to save |
| cseg_i | input | 8 | Code segment byte to save |
| sp_i | input | ADDR_W | Stack pointer before entry |
| vbase_i | input | ADDR_W | Vector table base address |
| busy_o | output | 1 | Sequencer not idle |
| ien_clr_o | output | 1 | Clear the global interrupt enable |
| stk_we_o | output | 1 | Stack byte write strobe |
| stk_addr_o | output | ADDR_W | Stack byte address |
| stk_wdata_o | output | 8 | Stack byte data |
| vec_re_o | output | 1 | Vector byte read strobe |
| vec_addr_o | output | ADDR_W | Vector byte address |
| vec_rdata_i | input | 8 | Vector byte, returned one cycle after the read |
| done_o | output | 1 | New PC loaded, one cycle |
| pc_new_o | output | 16 | Handler address |
| sp_new_o | output | ADDR_W | Stack pointer after the pushes |

## Verification
The bench builds the block with the default values: a 16-bit address space, 4-bit index, base length 18, and 2 extra clocks each for the register-file stack and the segment push. This makes all four entry lengths (18, 20, 20, 22) reachable. It also allows a stack pointer of 2, so the pushes wrap below zero, and a vector base of 0xFFFE, so the vector read wraps past the top of the address space. The largest index exercises the full doubling of the vector offset. The bench also varies the waiting window from zero extra cycles to 21, and it disturbs every input during the wait and during the run.

// File: rtl/iex_pkg.sv
package iex_pkg;
  localparam int BYTE_W    = 8;
  localparam int MAX_PUSH  = 4;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_WAIT = 2'd1,
    SEQ_RUN  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/iex_ctrl.sv
module iex_ctrl
  import iex_pkg::*;
#(
  parameter int BASE_LEN  = 18,
  parameter int RF_EXTRA  = 2,
  parameter int SEG_EXTRA = 2,
  parameter int CNT_W     = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ack_i,
  input  logic             nis_end_i,
  input  logic             stk_rf_i,
  input  logic             seg_save_i,
  output logic             busy_o,
  output logic             run_o,
  output logic             take_o,
  output logic             seg_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] last_o
);
  localparam logic [CNT_W-1:0] L_BASE = CNT_W'(BASE_LEN);
  localparam logic [CNT_W-1:0] L_RF   = CNT_W'(RF_EXTRA);
  localparam logic [CNT_W-1:0] L_SEG  = CNT_W'(SEG_EXTRA);

  seq_state_e       st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             rf_q, seg_q;
  logic [CNT_W-1:0] len;

  assign take_o = (st_q == SEQ_IDLE) && ack_i;
  assign len    = L_BASE + (rf_q ? L_RF : '0) + (seg_q ? L_SEG : '0);
  assign last_o = len - CNT_W'(1);

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    case (st_q)
      SEQ_IDLE: if (ack_i) st_d = SEQ_WAIT;
      SEQ_WAIT: if (nis_end_i) begin
        st_d  = SEQ_RUN;
        cnt_d = '0;
      end
      SEQ_RUN: begin
        if (cnt_q == last_o) begin
          st_d  = SEQ_IDLE;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      default: st_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SEQ_IDLE;
      cnt_q <= '0;
      rf_q  <= 1'b0;
      seg_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      if (take_o) begin
        rf_q  <= stk_rf_i;
        seg_q <= seg_save_i;
      end
    end
  end

  assign busy_o = (st_q != SEQ_IDLE);
  assign run_o  = (st_q == SEQ_RUN);
  assign seg_o  = seg_q;
  assign cnt_o  = cnt_q;

  AST_RUN_NEEDS_NIS: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SEQ_WAIT && !nis_end_i) |=> (st_q == SEQ_WAIT)); // R2
endmodule

// File: rtl/iex_push.sv
module iex_push
  import iex_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_i,
  input  logic              run_i,
  input  logic              seg_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [15:0]       pc_i,
  input  logic [BYTE_W-1:0] flags_i,
  input  logic [BYTE_W-1:0] cseg_i,
  input  logic [ADDR_W-1:0] sp_i,
  output logic              we_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BYTE_W-1:0] wdata_o,
  output logic [ADDR_W-1:0] sp_new_o
);
  localparam int SLOT_W = $clog2(MAX_PUSH);

  logic [15:0]       pc_q;
  logic [BYTE_W-1:0] flags_q, cseg_q;
  logic [ADDR_W-1:0] sp_q;
  logic [CNT_W-1:0]  off, half;
  logic [CNT_W-1:0]  npush;
  logic [SLOT_W-1:0] slot;
  logic [BYTE_W-1:0] slot_byte [MAX_PUSH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q    <= '0;
      flags_q <= '0;
      cseg_q  <= '0;
      sp_q    <= '0;
    end else if (take_i) begin
      pc_q    <= pc_i;
      flags_q <= flags_i;
      cseg_q  <= cseg_i;
      sp_q    <= sp_i;
    end
  end

  // push order: PC low, PC high, flags, code segment
  assign slot_byte[0] = pc_q[7:0];
  assign slot_byte[1] = pc_q[15:8];
  assign slot_byte[2] = flags_q;
  assign slot_byte[3] = cseg_q;

  assign npush = seg_i ? CNT_W'(MAX_PUSH) : CNT_W'(MAX_PUSH - 1);
  assign off   = cnt_i - CNT_W'(2);
  assign half  = off >> 1;
  assign slot  = half[SLOT_W-1:0];

  assign we_o     = run_i && (cnt_i >= CNT_W'(2)) && !off[0] && (half < npush);
  assign addr_o   = sp_q - ADDR_W'(slot) - ADDR_W'(1);
  assign wdata_o  = slot_byte[slot];
  assign sp_new_o = sp_q - ADDR_W'(npush);

  AST_PUSH_BELOW_SP: assert property (@(posedge clk) disable iff (!rst_n)
    we_o |-> ((ADDR_W'(sp_q - addr_o) >= ADDR_W'(1)) &&
              (ADDR_W'(sp_q - addr_o) <= ADDR_W'(MAX_PUSH)))); // R3
endmodule

// File: rtl/iex_vec.sv
module iex_vec
  import iex_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 4,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_i,
  input  logic              busy_i,
  input  logic              run_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [CNT_W-1:0]  last_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [ADDR_W-1:0] vbase_i,
  input  logic [BYTE_W-1:0] rdata_i,
  output logic              re_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [15:0]       pc_new_o
);
  logic [IDX_W-1:0]  idx_q;
  logic [ADDR_W-1:0] vbase_q, vaddr;
  logic [BYTE_W-1:0] lo_q, hi_q;
  logic              rd_lo, rd_hi, cap_lo, cap_hi;

  assign vaddr  = vbase_q + (ADDR_W'(idx_q) << 1);
  assign rd_lo  = run_i && (cnt_i == last_i - CNT_W'(4));
  assign rd_hi  = run_i && (cnt_i == last_i - CNT_W'(2));
  assign cap_lo = run_i && (cnt_i == last_i - CNT_W'(3));
  assign cap_hi = run_i && (cnt_i == last_i - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q   <= '0;
      vbase_q <= '0;
      lo_q    <= '0;
      hi_q    <= '0;
    end else begin
      if (take_i) begin
        idx_q   <= idx_i;
        vbase_q <= vbase_i;
      end
      if (cap_lo) lo_q <= rdata_i;
      if (cap_hi) hi_q <= rdata_i;
    end
  end

  assign re_o     = rd_lo || rd_hi;
  assign addr_o   = rd_hi ? vaddr + ADDR_W'(1) : vaddr;
  assign pc_new_o = {hi_q, lo_q};

  AST_IDX_HELD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && $past(busy_i)) |-> $stable(idx_q)); // R7
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import iex_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int IDX_W     = 4,
  parameter int BASE_LEN  = 18,
  parameter int RF_EXTRA  = 2,
  parameter int SEG_EXTRA = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ack_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              nis_end_i,
  input  logic              stk_rf_i,
  input  logic              seg_save_i,
  input  logic [15:0]       pc_i,
  input  logic [7:0]        flags_i,
  input  logic [7:0]        cseg_i,
  input  logic [ADDR_W-1:0] sp_i,
  input  logic [ADDR_W-1:0] vbase_i,
  output logic              busy_o,
  output logic              ien_clr_o,
  output logic              stk_we_o,
  output logic [ADDR_W-1:0] stk_addr_o,
  output logic [7:0]        stk_wdata_o,
  output logic              vec_re_o,
  output logic [ADDR_W-1:0] vec_addr_o,
  input  logic [7:0]        vec_rdata_i,
  output logic              done_o,
  output logic [15:0]       pc_new_o,
  output logic [ADDR_W-1:0] sp_new_o
);
  localparam int CNT_W = $clog2(BASE_LEN + RF_EXTRA + SEG_EXTRA);

  logic             run, take, seg;
  logic [CNT_W-1:0] cnt, last;

  iex_ctrl #(
    .BASE_LEN (BASE_LEN),
    .RF_EXTRA (RF_EXTRA),
    .SEG_EXTRA(SEG_EXTRA),
    .CNT_W    (CNT_W)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .ack_i     (ack_i),
    .nis_end_i (nis_end_i),
    .stk_rf_i  (stk_rf_i),
    .seg_save_i(seg_save_i),
    .busy_o    (busy_o),
    .run_o     (run),
    .take_o    (take),
    .seg_o     (seg),
    .cnt_o     (cnt),
    .last_o    (last)
  );

  iex_push #(
    .ADDR_W(ADDR_W),
    .CNT_W (CNT_W)
  ) u_push (
    .clk     (clk),
    .rst_n   (rst_n),
    .take_i  (take),
    .run_i   (run),
    .seg_i   (seg),
    .cnt_i   (cnt),
    .pc_i    (pc_i),
    .flags_i (flags_i),
    .cseg_i  (cseg_i),
    .sp_i    (sp_i),
    .we_o    (stk_we_o),
    .addr_o  (stk_addr_o),
    .wdata_o (stk_wdata_o),
    .sp_new_o(sp_new_o)
  );

  iex_vec #(
    .ADDR_W(ADDR_W),
    .IDX_W (IDX_W),
    .CNT_W (CNT_W)
  ) u_vec (
    .clk     (clk),
    .rst_n   (rst_n),
    .take_i  (take),
    .busy_i  (busy_o),
    .run_i   (run),
    .cnt_i   (cnt),
    .last_i  (last),
    .idx_i   (idx_i),
    .vbase_i (vbase_i),
    .rdata_i (vec_rdata_i),
    .re_o    (vec_re_o),
    .addr_o  (vec_addr_o),
    .pc_new_o(pc_new_o)
  );

  assign ien_clr_o = run && (cnt == '0);
  assign done_o    = run && (cnt == last);

  AST_IEN_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
    ien_clr_o |-> (!stk_we_o && !vec_re_o && !done_o)); // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!done_o && !busy_o)); // R6
  AST_VEC_BEFORE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(vec_re_o, 2)); // R5
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!stk_we_o && !vec_re_o)); // R4
endmodule

// File: tb/irq_entry_seq_tb_top.sv
`timescale 1ns/1ps
module irq_entry_seq_tb_top;
  localparam int AW = 16;
  localparam int IW = 4;

  typedef struct {
    int    kind;   // 0 ien, 1 push, 2 vector read, 3 done
    int    addr;
    int    data;
    int    off;
    string req;
  } item_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ack = 1'b0, nis_end = 1'b0, stk_rf = 1'b0, seg_save = 1'b0;
  logic [IW-1:0] idx = '0;
  logic [15:0]   pc = '0;
  logic [7:0]    flags = '0, cseg = '0;
  logic [AW-1:0] sp = '0, vbase = '0;
  logic          busy, ien_clr, stk_we, vec_re, done;
  logic [AW-1:0] stk_addr, vec_addr, sp_new;
  logic [7:0]    stk_wdata;
  logic [7:0]    vec_rdata = '0;
  logic [15:0]   pc_new;

  int    n_vec = 0, n_bad = 0, cyc = 0, base_cyc = 0;
  item_t exp_q[$];

  always #2 clk = ~clk;

  irq_entry_seq dut_i (
    .clk(clk), .rst_n(rst_n), .ack_i(ack), .idx_i(idx), .nis_end_i(nis_end),
    .stk_rf_i(stk_rf), .seg_save_i(seg_save), .pc_i(pc), .flags_i(flags),
    .cseg_i(cseg), .sp_i(sp), .vbase_i(vbase), .busy_o(busy),
    .ien_clr_o(ien_clr), .stk_we_o(stk_we), .stk_addr_o(stk_addr),
    .stk_wdata_o(stk_wdata), .vec_re_o(vec_re), .vec_addr_o(vec_addr),
    .vec_rdata_i(vec_rdata), .done_o(done), .pc_new_o(pc_new), .sp_new_o(sp_new)
  );

  function automatic logic [7:0] vmem(input logic [AW-1:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction

  always @(posedge clk) if (vec_re) vec_rdata <= vmem(vec_addr);

  task automatic check(input string req, input int act, input int expv);
    n_vec++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
    end
  endtask

  function automatic void put(input int k, input int a, input int d, input int o,
                              input string r);
    item_t it;
    it.kind = k; it.addr = a; it.data = d; it.off = o; it.req = r;
    exp_q.push_back(it);
  endfunction

  task automatic observe(input int k, input int a, input int d);
    item_t it;
    if (exp_q.size() == 0) begin
      check("R7 unexpected event kind", k, -1);
      return;
    end
    it = exp_q.pop_front();
    check({it.req, " kind"}, k, it.kind);
    check({it.req, " cycle"}, cyc - base_cyc, it.off);
    check({it.req, " addr"}, a, it.addr);
    check({it.req, " data"}, d, it.data);
  endtask

  // monitor: compares design events against the scoreboard queue
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (ien_clr) begin
        base_cyc = cyc;
        observe(0, 0, 0);
      end
      if (stk_we) observe(1, int'(stk_addr), int'(stk_wdata));
      if (vec_re) observe(2, int'(vec_addr), 0);
      if (done) observe(3, int'(sp_new), int'(pc_new));
    end
  end

  task automatic run_entry(input logic rf, input logic sg, input logic [IW-1:0] ix,
                           input logic [15:0] p, input logic [7:0] f,
                           input logic [7:0] c, input logic [AW-1:0] s,
                           input logic [AW-1:0] vb, input int waitc,
                           input bit disturb);
    int len, np;
    logic [AW-1:0] va;
    len = 18 + (rf ? 2 : 0) + (sg ? 2 : 0);
    np  = sg ? 4 : 3;
    va  = vb + (AW'(ix) << 1);
    put(0, 0, 0, 0, "R2 ien");
    put(1, int'(AW'(s - 1)), int'(p[7:0]),  2, "R3 pc low");
    put(1, int'(AW'(s - 2)), int'(p[15:8]), 4, "R3 pc high");
    put(1, int'(AW'(s - 3)), int'(f),       6, "R3 flags");
    if (sg) put(1, int'(AW'(s - 4)), int'(c), 8, "R3 segment");
    put(2, int'(va), 0, len - 5, "R5 vec low");
    put(2, int'(AW'(va + 1)), 0, len - 3, "R5 vec high");
    put(3, int'(AW'(s - AW'(np))), int'({vmem(AW'(va + 1)), vmem(va)}), len - 1,
        "R4 R6 done");
    @(negedge clk);
    ack = 1'b1; idx = ix; pc = p; flags = f; cseg = c; sp = s; vbase = vb;
    stk_rf = rf; seg_save = sg;
    @(negedge clk);
    ack = 1'b0;
    if (disturb) begin  // R8: change operands after the sample
      idx = ~ix; pc = ~p; flags = ~f; cseg = ~c; sp = ~s; vbase = ~vb;
      stk_rf = ~rf; seg_save = ~sg; ack = 1'b1;   // R7 ack in wait
    end
    for (int i = 0; i < waitc; i++) begin
      check("R2 busy while waiting", int'(busy), 1);
      check("R2 no ien while waiting", int'(ien_clr), 0);
      @(negedge clk);
    end
    nis_end = 1'b1;
    @(negedge clk);
    nis_end = 1'b0;
    ack = 1'b0;
    for (int i = 0; i < 40 && busy; i++) begin
      ack = (disturb && i == 3);   // R7 ack during run
      @(negedge clk);
    end
    ack = 1'b0;
    check("R6 idle after done", int'(busy), 0);
    repeat (3) @(negedge clk);
    check("R7 no second entry", int'(busy), 0);
    check("R3 R5 all events seen", exp_q.size(), 0);
    exp_q.delete();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 busy", int'(busy), 0);
    check("R1 ien", int'(ien_clr), 0);
    check("R1 we", int'(stk_we), 0);
    check("R1 re", int'(vec_re), 0);
    check("R1 done", int'(done), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    run_entry(1'b0, 1'b0, 4'd3,  16'h1234, 8'h5C, 8'h07, 16'h0200, 16'h0040, 0,  1'b0);
    run_entry(1'b1, 1'b0, 4'd0,  16'hBEEF, 8'h81, 8'h11, 16'h8000, 16'h1000, 15, 1'b0);
    run_entry(1'b0, 1'b1, 4'd15, 16'hA55A, 8'h3C, 8'h9E, 16'h0002, 16'h2000, 21, 1'b0);
    run_entry(1'b1, 1'b1, 4'd1,  16'h0F0F, 8'hE1, 8'h42, 16'h4321, 16'hFFFE, 1,  1'b0);
    run_entry(1'b0, 1'b1, 4'd9,  16'hC0DE, 8'h66, 8'hAB, 16'h0100, 16'h0300, 5,  1'b1);
    run_entry(1'b1, 1'b0, 4'd6,  16'h7701, 8'h12, 8'h34, 16'h0000, 16'h0500, 19, 1'b1);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule